// File: doc/BRIEF.md
# Dual-Path Floating-Point Adder

This block adds or subtracts two binary floating-point numbers of a configurable width. The default is the 64-bit layout: one sign bit, an 11-bit biased exponent and 52 stored fraction bits behind an implicit leading one. Operands and an add/subtract select enter through a valid/ready handshake. The packed result leaves through a second valid/ready handshake. Between the two handshakes there are three register stages. The first stage decodes both operands, sorts them by magnitude and classifies the operation. The second stage aligns the smaller significand and adds or subtracts it. The third stage normalises, rounds and packs the result.

Each operation is steered onto one of four routes, called `ROUTE_BYPASS`, `ROUTE_SPECIAL`, `ROUTE_FAR` and `ROUTE_NEAR`.
- `ROUTE_FAR` handles an effective addition, or an effective subtraction whose exponent gap is at least two. Its result needs at most a one-place shift before rounding.
- `ROUTE_NEAR` handles an effective subtraction whose exponent gap is zero or one. It finds the leading one of the difference and shifts left by the full count.
- `ROUTE_BYPASS` handles a zero operand. The result word is formed in the first stage and carried in order beside the datapath. The alignment, adder and normaliser registers are not loaded for it.
- `ROUTE_SPECIAL` does the same for NaN and infinity operands.

The output register is a two-state slot.
- The states are `SLOT_EMPTY` and `SLOT_FULL`.
- Transition *fill*: `SLOT_EMPTY` goes to `SLOT_FULL` when the last stage holds a valid result.
- Transition *drain*: `SLOT_FULL` goes to `SLOT_EMPTY` when the consumer takes the result and nothing follows it.
- Transition *refill*: `SLOT_FULL` stays in `SLOT_FULL` with a new word when the consumer takes the result and another one follows.
- Transition *hold*: `SLOT_FULL` stays in `SLOT_FULL` unchanged while `out_ready` is low.

The whole pipe advances whenever the slot is empty or is being drained.

Top module: `fpadd_dualpath`

## Requirements
- R1: With both operands normal, the result is the exact sum rounded to nearest with ties to the even significand. The format is sign in the top bit, then an EXP_W-bit exponent with bias 2^(EXP_W-1)-1, then FRAC_W fraction bits with a hidden one.
- R2: When `in_sub` is 1 the result is `in_a` minus `in_b`, obtained by inverting the sign of `in_b` before any other processing.
- R3: An effective addition, or an effective subtraction with exponent gap of two or more, gives the correctly rounded result through a normalisation of at most one place.
- R4: An effective subtraction with exponent gap below two gives the correctly rounded difference, including massive cancellation. An exact cancellation gives +0 (all bits zero).
- R5: A result whose rounded exponent reaches the all-ones code becomes an infinity of the result sign: exponent all ones, fraction zero.
- R6: A nonzero result below the smallest normal magnitude becomes a zero of the result sign. No output ever has exponent zero with a nonzero fraction.
- R7: An input with exponent code zero is treated as a zero of its own sign, whatever its fraction.
- R8: If exactly one operand is zero, the result is the other operand bit for bit, with the sign of `in_b` inverted when subtracting. If both are zero, the result is -0 only when both effective signs are negative, and +0 otherwise.
- R9: Any NaN input (exponent all ones, fraction nonzero) gives the quiet NaN with sign 0, exponent all ones, fraction MSB 1 and other fraction bits 0.
- R10: An infinity plus a finite value, or two infinities of equal effective sign, gives that infinity. Infinities of opposite effective sign give the quiet NaN of R9.
- R11: An operation is taken on a cycle with `in_valid` and `in_ready` both high. Results leave in acceptance order, with none lost or repeated. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block takes the pair this cycle |
| in_a | input | EXP_W+FRAC_W+1 | First operand |
| in_b | input | EXP_W+FRAC_W+1 | Second operand |
| in_sub | input | 1 | 1 selects a minus b, 0 selects a plus b |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | EXP_W+FRAC_W+1 | Packed result |

## Verification
The bench builds the adder with EXP_W=4 and FRAC_W=3, which gives an 8-bit word with 256 codes. It then applies every ordered operand pair for both addition and subtraction. That reaches every exponent gap, including gaps beyond the alignment width, and every tie and sticky pattern in rounding. It also reaches overflow into infinity, cancellation down to zero and below the smallest normal, and every mix of zero, subnormal, infinity and NaN operands. A final random phase throttles `out_ready` to exercise the hold and ordering rules of the output slot.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    typedef enum logic [1:0] {
        ROUTE_BYPASS  = 2'd0,
        ROUTE_SPECIAL = 2'd1,
        ROUTE_FAR     = 2'd2,
        ROUTE_NEAR    = 2'd3
    } route_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/fpadd_unpack.sv
// Stage 1: decode, magnitude sort, route choice, early result for special/zero lanes.
module fpadd_unpack
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = EXP_W + FRAC_W + 1,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int SH_W   = $clog2(EXT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              op_sub,
    output logic              v_q,
    output route_e            route_q,
    output logic [WORD_W-1:0] word_q,
    output logic              sign_q,
    output logic              effsub_q,
    output logic [EXP_W-1:0]  exp_q,
    output logic [SIG_W-1:0]  bsig_q,
    output logic [SIG_W-1:0]  ssig_q,
    output logic [SH_W-1:0]   sh_q
);
    localparam logic [EXP_W-1:0]  EMAX   = '1;
    localparam logic [EXP_W-1:0]  SH_CAP = EXP_W'(EXT_W);
    localparam logic [WORD_W-1:0] QNAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [EXP_W-1:0]  ea, eb, e_big, e_small, diff;
    logic [FRAC_W-1:0] fa, fb, f_big, f_small;
    logic              sa, sb, s_big, eff_sub, a_first;
    logic              a_zero, b_zero, a_nan, b_nan, a_inf, b_inf;
    logic [SH_W-1:0]   sh;
    route_e            route;
    logic [WORD_W-1:0] word;

    assign ea = opa[WORD_W-2:FRAC_W];
    assign eb = opb[WORD_W-2:FRAC_W];
    assign fa = opa[FRAC_W-1:0];
    assign fb = opb[FRAC_W-1:0];
    assign sa = opa[WORD_W-1];
    assign sb = opb[WORD_W-1] ^ op_sub;

    assign a_zero = (ea == '0);
    assign b_zero = (eb == '0);
    assign a_nan  = (ea == EMAX) && (fa != '0);
    assign b_nan  = (eb == EMAX) && (fb != '0);
    assign a_inf  = (ea == EMAX) && (fa == '0);
    assign b_inf  = (eb == EMAX) && (fb == '0);

    assign a_first = (opa[WORD_W-2:0] >= opb[WORD_W-2:0]);
    assign e_big   = a_first ? ea : eb;
    assign e_small = a_first ? eb : ea;
    assign f_big   = a_first ? fa : fb;
    assign f_small = a_first ? fb : fa;
    assign s_big   = a_first ? sa : sb;
    assign diff    = e_big - e_small;
    assign eff_sub = sa ^ sb;
    assign sh      = (diff > SH_CAP) ? SH_W'(EXT_W) : SH_W'(diff);

    always_comb begin
        route = ROUTE_FAR;
        word  = '0;
        if (a_nan || b_nan) begin
            route = ROUTE_SPECIAL;
            word  = QNAN;
        end else if (a_inf || b_inf) begin
            route = ROUTE_SPECIAL;
            if (a_inf && b_inf && eff_sub) word = QNAN;
            else if (a_inf)                word = {sa, EMAX, {FRAC_W{1'b0}}};
            else                           word = {sb, EMAX, {FRAC_W{1'b0}}};
        end else if (a_zero || b_zero) begin
            route = ROUTE_BYPASS;
            if (a_zero && b_zero) word = {sa & sb, {(WORD_W-1){1'b0}}};
            else if (a_zero)      word = {sb, opb[WORD_W-2:0]};
            else                  word = opa;
        end else if (eff_sub && (diff < EXP_W'(2))) begin
            route = ROUTE_NEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else if (adv) v_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            route_q <= route;
            word_q  <= word;
        end
        // arithmetic registers stay still for bypassed and special operations
        if (adv && in_valid && (route == ROUTE_FAR || route == ROUTE_NEAR)) begin
            sign_q   <= s_big;
            effsub_q <= eff_sub;
            exp_q    <= e_big;
            bsig_q   <= {1'b1, f_big};
            ssig_q   <= {1'b1, f_small};
            sh_q     <= sh;
        end
    end
endmodule

// File: rtl/fpadd_align_add.sv
// Stage 2: right-align the smaller significand with guard/round/sticky, then add or subtract.
module fpadd_align_add
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = EXP_W + FRAC_W + 1,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int SUM_W  = EXT_W + 1,
    localparam int SH_W   = $clog2(EXT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              v_in,
    input  route_e            route_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sign_in,
    input  logic              effsub_in,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [SIG_W-1:0]  bsig_in,
    input  logic [SIG_W-1:0]  ssig_in,
    input  logic [SH_W-1:0]   sh_in,
    output logic              v_q,
    output route_e            route_q,
    output logic [WORD_W-1:0] word_q,
    output logic              sign_q,
    output logic [EXP_W-1:0]  exp_q,
    output logic [SUM_W-1:0]  sum_q
);
    logic [2*EXT_W-1:0] wide;
    logic [EXT_W-1:0]   aligned;
    logic [SUM_W-1:0]   sum;
    logic               arith;

    assign arith   = (route_in == ROUTE_FAR) || (route_in == ROUTE_NEAR);
    assign wide    = {ssig_in, 3'b000, {EXT_W{1'b0}}} >> sh_in;
    assign aligned = wide[2*EXT_W-1:EXT_W] | {{(EXT_W-1){1'b0}}, |wide[EXT_W-1:0]};
    assign sum     = effsub_in ? ({1'b0, bsig_in, 3'b000} - {1'b0, aligned})
                               : ({1'b0, bsig_in, 3'b000} + {1'b0, aligned});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else if (adv) v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            route_q <= route_in;
            word_q  <= word_in;
        end
        if (adv && v_in && arith) begin
            sign_q <= sign_in;
            exp_q  <= exp_in;
            sum_q  <= sum;
        end
    end

    // magnitude sort in stage 1 guarantees a non-negative difference
    assert_sub_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && arith && effsub_in) |-> !sum[SUM_W-1]);
endmodule

// File: rtl/fpadd_norm.sv
// Stage 3a: far-path one-place fix-up or near-path leading-one normalise.
module fpadd_norm
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int SUM_W  = EXT_W + 1,
    localparam int SH_W   = $clog2(EXT_W + 1),
    localparam int XW     = EXP_W + 2
) (
    input  route_e                  route,
    input  logic [EXP_W-1:0]        exp_in,
    input  logic [SUM_W-1:0]        sum,
    output logic [EXT_W-1:0]        m,
    output logic signed [XW-1:0]    nexp,
    output logic                    is_zero
);
    logic signed [XW-1:0] base;
    logic [EXT_W-1:0]     far_m, near_m;
    logic signed [XW-1:0] far_e, near_e;
    logic [SH_W-1:0]      lz;
    logic                 found;

    assign base = $signed({2'b00, exp_in});

    always_comb begin
        if (sum[EXT_W]) begin
            far_m = {sum[EXT_W:2], sum[1] | sum[0]};
            far_e = base + XW'(1);
        end else if (sum[EXT_W-1]) begin
            far_m = sum[EXT_W-1:0];
            far_e = base;
        end else begin
            far_m = {sum[EXT_W-2:0], 1'b0};
            far_e = base - XW'(1);
        end
    end

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (sum[i]) found = 1'b1;
                else        lz = lz + 1'b1;
            end
        end
        near_m = sum[EXT_W-1:0] << lz;
        near_e = base - $signed({{(XW-SH_W){1'b0}}, lz});
    end

    always_comb begin
        unique case (route)
            ROUTE_NEAR: begin
                m       = near_m;
                nexp    = near_e;
                is_zero = (sum == '0);
            end
            default: begin
                m       = far_m;
                nexp    = far_e;
                is_zero = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpadd_round.sv
// Stage 3b: round to nearest even and pack, with overflow and underflow clamps.
module fpadd_round #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = EXP_W + FRAC_W + 1,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int XW     = EXP_W + 2
) (
    input  logic                 sign,
    input  logic [EXT_W-1:0]     m,
    input  logic signed [XW-1:0] nexp,
    output logic [WORD_W-1:0]    word
);
    localparam logic [EXP_W-1:0] EMAX = '1;

    logic [SIG_W-1:0]     keep;
    logic [SIG_W:0]       inc;
    logic                 up;
    logic signed [XW-1:0] rexp;

    assign keep = m[EXT_W-1:3];
    assign up   = m[2] & (m[1] | m[0] | keep[0]);
    assign inc  = {1'b0, keep} + {{SIG_W{1'b0}}, up};
    assign rexp = nexp + $signed({{(XW-1){1'b0}}, inc[SIG_W]});

    always_comb begin
        if (rexp <= $signed(XW'(0)))
            word = {sign, {(WORD_W-1){1'b0}}};
        else if (rexp >= $signed({2'b00, EMAX}))
            word = {sign, EMAX, {FRAC_W{1'b0}}};
        else
            word = {sign, rexp[EXP_W-1:0], inc[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fpadd_dualpath.sv
module fpadd_dualpath
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = EXP_W + FRAC_W + 1,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int SUM_W  = EXT_W + 1,
    localparam int SH_W   = $clog2(EXT_W + 1),
    localparam int XW     = EXP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic              in_sub,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    localparam logic [EXP_W-1:0]  EMAX = '1;
    localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    slot_e                state;
    logic                 adv;

    logic                 v1, sign1, effsub1;
    route_e               route1;
    logic [WORD_W-1:0]    word1;
    logic [EXP_W-1:0]     exp1;
    logic [SIG_W-1:0]     bsig1, ssig1;
    logic [SH_W-1:0]      sh1;

    logic                 v2, sign2;
    route_e               route2;
    logic [WORD_W-1:0]    word2;
    logic [EXP_W-1:0]     exp2;
    logic [SUM_W-1:0]     sum2;

    logic [EXT_W-1:0]     m3;
    logic signed [XW-1:0] nexp3;
    logic                 zero3;
    logic [WORD_W-1:0]    rounded3, result3;

    assign adv      = (state == SLOT_EMPTY) || out_ready;
    assign in_ready = adv;

    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
        .opa(in_a), .opb(in_b), .op_sub(in_sub),
        .v_q(v1), .route_q(route1), .word_q(word1), .sign_q(sign1),
        .effsub_q(effsub1), .exp_q(exp1), .bsig_q(bsig1), .ssig_q(ssig1), .sh_q(sh1)
    );

    fpadd_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(v1), .route_in(route1),
        .word_in(word1), .sign_in(sign1), .effsub_in(effsub1), .exp_in(exp1),
        .bsig_in(bsig1), .ssig_in(ssig1), .sh_in(sh1),
        .v_q(v2), .route_q(route2), .word_q(word2), .sign_q(sign2),
        .exp_q(exp2), .sum_q(sum2)
    );

    fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .route(route2), .exp_in(exp2), .sum(sum2),
        .m(m3), .nexp(nexp3), .is_zero(zero3)
    );

    fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign(sign2), .m(m3), .nexp(nexp3), .word(rounded3)
    );

    always_comb begin
        unique case (route2)
            ROUTE_BYPASS, ROUTE_SPECIAL: result3 = word2;
            ROUTE_FAR:                   result3 = rounded3;
            ROUTE_NEAR:                  result3 = zero3 ? '0 : rounded3;
        endcase
    end

    // output slot: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else if (adv) state <= v2 ? SLOT_FULL : SLOT_EMPTY;
    end

    // output slot: data
    always_ff @(posedge clk) begin
        if (adv && v2) out_data <= result3;
    end

    assign out_valid = (state == SLOT_FULL);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_qnan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[WORD_W-2:FRAC_W] == EMAX && out_data[FRAC_W-1:0] != '0)
            |-> (out_data == QNAN));

    assert_no_subnormal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_data[WORD_W-2:FRAC_W] == '0 && out_data[FRAC_W-1:0] != '0));

    assert_far_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && route2 == ROUTE_FAR) |-> (sum2[EXT_W:EXT_W-2] != 3'b000));
endmodule

// File: tb/sim_fpadd_dualpath.sv
module sim_fpadd_dualpath;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 4;
    localparam int FW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_a = '0;
    logic [7:0] in_b = '0;
    logic       in_sub = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         bp_mode = 1'b0;
    bit         stall_prev = 1'b0;
    logic [7:0] stall_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpadd_dualpath #(.EXP_W(EW), .FRAC_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // arithmetic reference for 1/4/3 words
    function automatic void model(input logic [7:0] a, input logic [7:0] b, input logic s,
                                  output logic [7:0] r, output string tag);
        int ea, eb, fa, fb, va, vb, sum, mag, p, e, sh, keep, rem, half;
        logic sa, sb, sg;
        ea = int'(a[6:3]); fa = int'(a[2:0]); sa = a[7];
        eb = int'(b[6:3]); fb = int'(b[2:0]); sb = b[7] ^ s;
        if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0)) begin
            r = 8'h7C; tag = "R9";
        end else if (ea == 15 || eb == 15) begin
            tag = "R10";
            if (ea == 15 && eb == 15 && sa != sb) r = 8'h7C;
            else if (ea == 15)                    r = {sa, 7'h78};
            else                                  r = {sb, 7'h78};
        end else if (ea == 0 && eb == 0) begin
            r = {sa & sb, 7'h00};
            tag = (fa != 0 || fb != 0) ? "R7" : "R8";
        end else if (ea == 0) begin
            r = {sb, b[6:0]};
            tag = (fa != 0) ? "R7" : "R8";
        end else if (eb == 0) begin
            r = a;
            tag = (fb != 0) ? "R7" : "R8";
        end else begin
            va  = (8 + fa) << (ea - 1);
            vb  = (8 + fb) << (eb - 1);
            sum = (sa ? -va : va) + (sb ? -vb : vb);
            if (sa != sb && (ea - eb < 2) && (eb - ea < 2)) tag = "R4";
            else if (sa != sb) tag = "R3";
            else if (s)        tag = "R2";
            else               tag = "R1";
            if (sum == 0) begin
                r = 8'h00; tag = "R4";
            end else begin
                sg  = (sum < 0);
                mag = sg ? -sum : sum;
                p = 0;
                for (int i = 0; i < 24; i++) if (((mag >> i) & 1) != 0) p = i;
                e = p - 2;
                if (e <= 0) begin
                    r = {sg, 7'h00}; tag = "R6";
                end else begin
                    keep = mag;
                    if (p > 3) begin
                        sh   = p - 3;
                        keep = mag >> sh;
                        rem  = mag & ((1 << sh) - 1);
                        half = 1 << (sh - 1);
                        if (rem > half || (rem == half && (keep & 1) == 1)) keep++;
                        if (keep == 16) begin keep = 8; e++; end
                    end
                    if (e >= 15) begin
                        r = {sg, 7'h78}; tag = "R5";
                    end else begin
                        r = {sg, e[3:0], keep[2:0]};
                    end
                end
            end
        end
    endfunction

    task automatic observe();
        logic [7:0] e;
        string t;
        if (stall_prev) check(out_valid && out_data == stall_data, "R11 hold", out_data, stall_data);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 extra result", out_data, 8'h00);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data == e, t, out_data, e);
            end
        end
        stall_prev = out_valid && !out_ready;
        stall_data = out_data;
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] b, input logic s);
        logic [7:0] r;
        string t;
        bit acc;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            out_ready = bp_mode ? ($urandom_range(3) != 0) : 1'b1;
            in_a = a; in_b = b; in_sub = s; in_valid = 1'b1;
            #1;
            observe();
            acc = in_ready;
        end
        model(a, b, s, r, t);
        exp_q.push_back(r);
        tag_q.push_back(t);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=%0d pending expected=0", exp_q.size());
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", {7'h0, out_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R11 idle after reset",
              {6'h0, in_ready, out_valid}, 8'h02);

        // exhaustive sweep of both operations over every operand pair
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    send(8'(a), 8'(b), s[0]);

        // random operations with a throttled consumer (R11 order and hold)
        bp_mode = 1'b1;
        for (int k = 0; k < 3000; k++)
            send(8'($urandom), 8'($urandom), 1'($urandom));

        bp_mode = 1'b0;
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        observe();
        while (exp_q.size() > 0) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            observe();
        end
        repeat (4) begin
            @(negedge clk);
            #1;
            check(out_valid == 1'b0, "R11 no extra output", {7'h0, out_valid}, 8'h00);
        end
        finish_run();
    end
endmodule